// File: doc/BRIEF.md
# Ternary Match Engine with Selectable Entry Grouping

This block keeps a table of stored words. Each word has its own mask word. A search key is compared against every word at the same time. Each bit position is judged by three things: a global mask register shared by all entries, the entry's own mask bit, and the stored data bit. A search can span one entry, an aligned pair of entries or an aligned group of four entries. This is chosen by a width-mode input on each request, so keys one, two or four words wide can use the same storage.

Entries and the global mask are loaded through a single write port. A select bit on that port chooses between the data array and the mask array. A search request is answered one cycle later with a valid pulse, a hit flag and the index of the lowest matching group. A write presented in the same cycle as a search is seen by that search.

Top module: `tmatch_engine`

## Requirements
- R1: Where the global mask bit is 0, that bit position matches for every entry, whatever the key, data and entry mask hold.
- R2: Where the global mask bit is 1 and the entry's mask bit is 0, the position matches whatever the key and data bits are.
- R3: Where both the global mask bit and the entry mask bit are 1, the position matches only when the key bit equals the stored data bit.
- R4: In single mode, an entry is a hit only when all ENT_W positions match. The entry is compared with key chunk 0, which is `srch_key[ENT_W-1:0]`; the upper chunks are ignored.
- R5: In pair mode, a group is an even entry plus the next odd entry. The even entry is compared with chunk 0 and the odd entry with chunk 1 (`srch_key[2*ENT_W-1:ENT_W]`). Both entries must match fully, and the reported index is even.
- R6: In quad mode, a group is four entries starting at a multiple of four. Entry base+k is compared with chunk k, which is `srch_key[(k+1)*ENT_W-1:k*ENT_W]`. All four entries must match, and the reported index is a multiple of four.
- R7: `cfg_width` encodes the mode as 0 = single, 1 = pair, 2 = quad; the value 3 behaves as single.
- R8: When several groups hit, `rsp_idx` is the index of the first entry of the lowest-numbered group that hit.
- R9: `rsp_valid` is 1 exactly in the cycle after a cycle with `srch_req` = 1. When there is no request, `rsp_hit` and `rsp_idx` keep their values.
- R10: A response with `rsp_hit` = 0 carries `rsp_idx` = 0.
- R11: A data, mask or global-mask write that is presented in the same cycle as a search takes effect before that search compares.
- R12: Reset clears all data and entry-mask bits to 0, sets the global mask to all ones, and clears `rsp_valid`, `rsp_hit` and `rsp_idx`. Because the entry masks are all 0 after reset, every entry matches any key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one table word |
| wr_is_mask | input | 1 | 1 = write the mask array, 0 = write the data array |
| wr_addr | input | $clog2(ENTRIES) | Entry index to write |
| wr_word | input | ENT_W | Word to write |
| gm_wr_en | input | 1 | Load the global mask register |
| gm_word | input | ENT_W | New global mask value |
| cfg_width | input | 2 | Grouping mode of this search |
| srch_req | input | 1 | Search request |
| srch_key | input | 4*ENT_W | Search key, chunk k in bits [(k+1)*ENT_W-1:k*ENT_W] |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | At least one group matched |
| rsp_idx | output | $clog2(ENTRIES) | First entry of the winning group, 0 on a miss |

## Verification
Every bit position is swept through all sixteen combinations of global mask, entry mask, data and key bit. A design that swapped the roles of the two masks, or that compared bits when a mask said to ignore them, would report hits where none belong, or the reverse.

Directed searches probe several corner cases:
- keys that match a pair or a quad that is not aligned, which a design with wrong grouping would accept;
- keys with their chunks in swapped order;
- a key that matches only because the write in the same cycle lands first, which a design reading the old table would miss;
- two entries that both match, where only the lower index is allowed to win.

A long seeded random run covers all four mode codes against an arithmetic model. It also checks that a miss always reports index 0.

// File: rtl/tmatch_pkg.sv
package tmatch_pkg;

    typedef enum logic [1:0] {
        GRP_X1  = 2'd0,
        GRP_X2  = 2'd1,
        GRP_X4  = 2'd2,
        GRP_RSV = 2'd3
    } grp_mode_e;

endpackage

// File: rtl/tmatch_store.sv
module tmatch_store #(
    parameter int ENT_W   = 68,
    parameter int ENTRIES = 64,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_is_mask,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [ENT_W-1:0]              wr_word,
    input  logic                          gm_wr_en,
    input  logic [ENT_W-1:0]              gm_word,
    output logic [ENTRIES-1:0][ENT_W-1:0] data_nx,
    output logic [ENTRIES-1:0][ENT_W-1:0] mask_nx,
    output logic [ENT_W-1:0]              gm_nx
);

    typedef struct packed {
        logic [ENTRIES-1:0][ENT_W-1:0] data;
        logic [ENTRIES-1:0][ENT_W-1:0] mask;
        logic [ENT_W-1:0]              gm;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_addr) < ENTRIES)) begin
            if (wr_is_mask) st_d.mask[wr_addr] = wr_word;
            else            st_d.data[wr_addr] = wr_word;
        end
        if (gm_wr_en) st_d.gm = gm_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= '0;
            st_q.mask <= '0;
            st_q.gm   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // Write-first view handed to the comparators (R11)
    assign data_nx = st_d.data;
    assign mask_nx = st_d.mask;
    assign gm_nx   = st_d.gm;

    a_r11_data_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_is_mask |=> st_q.data[$past(wr_addr)] == $past(wr_word));

    a_r11_mask_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_is_mask |=> st_q.mask[$past(wr_addr)] == $past(wr_word));

    a_r11_gm_lands: assert property (@(posedge clk) disable iff (!rst_n)
        gm_wr_en |=> st_q.gm == $past(gm_word));

endmodule

// File: rtl/tmatch_cmp.sv
module tmatch_cmp
    import tmatch_pkg::*;
#(
    parameter int ENT_W   = 68,
    parameter int ENTRIES = 64,
    localparam int KEY_W  = 4 * ENT_W
) (
    input  logic [KEY_W-1:0]              key,
    input  grp_mode_e                     mode,
    input  logic [ENTRIES-1:0][ENT_W-1:0] data,
    input  logic [ENTRIES-1:0][ENT_W-1:0] mask,
    input  logic [ENT_W-1:0]              gm,
    output logic [ENTRIES-1:0]            ent_hit
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        localparam int POS2 = i % 2;
        localparam int POS4 = i % 4;

        logic [1:0]       csel;
        logic [ENT_W-1:0] seg;
        logic [ENT_W-1:0] bit_ok;

        // Which key chunk this entry faces depends on its place in the group
        always_comb begin
            case (mode)
                GRP_X2:  csel = 2'(POS2);
                GRP_X4:  csel = 2'(POS4);
                default: csel = 2'd0;
            endcase
        end

        assign seg     = key[csel*ENT_W +: ENT_W];
        assign bit_ok  = ~gm | ~mask[i] | ~(seg ^ data[i]);
        assign ent_hit[i] = &bit_ok;
    end

endmodule

// File: rtl/tmatch_grp.sv
module tmatch_grp
    import tmatch_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] ent_hit,
    input  grp_mode_e          mode,
    output logic               any_hit,
    output logic [AW-1:0]      first_idx
);

    localparam int NPAIR = ENTRIES / 2;
    localparam int NQUAD = ENTRIES / 4;

    logic [NPAIR-1:0]   pair_hit;
    logic [NQUAD-1:0]   quad_hit;
    logic [ENTRIES-1:0] grp_hit;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_hit[p] = ent_hit[2*p] & ent_hit[2*p+1];
    end

    for (genvar q = 0; q < NQUAD; q++) begin : g_quad
        assign quad_hit[q] = pair_hit[2*q] & pair_hit[2*q+1];
    end

    // Place each group's verdict at the index of its first entry
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            case (mode)
                GRP_X2:  grp_hit[i] = (i % 2 == 0) ? pair_hit[i/2] : 1'b0;
                GRP_X4:  grp_hit[i] = (i % 4 == 0) ? quad_hit[i/4] : 1'b0;
                default: grp_hit[i] = ent_hit[i];
            endcase
        end
    end

    // Lowest index wins
    always_comb begin
        any_hit   = 1'b0;
        first_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (grp_hit[i]) begin
                any_hit   = 1'b1;
                first_idx = AW'(i);
            end
        end
    end

endmodule

// File: rtl/tmatch_engine.sv
module tmatch_engine
    import tmatch_pkg::*;
#(
    parameter int ENT_W   = 68,
    parameter int ENTRIES = 64,
    localparam int AW     = $clog2(ENTRIES),
    localparam int KEY_W  = 4 * ENT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_is_mask,
    input  logic [AW-1:0]    wr_addr,
    input  logic [ENT_W-1:0] wr_word,
    input  logic             gm_wr_en,
    input  logic [ENT_W-1:0] gm_word,
    input  logic [1:0]       cfg_width,
    input  logic             srch_req,
    input  logic [KEY_W-1:0] srch_key,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [AW-1:0]    rsp_idx
);

    typedef struct packed {
        logic          valid;
        logic          hit;
        logic [AW-1:0] idx;
    } rsp_t;

    logic [ENTRIES-1:0][ENT_W-1:0] data_nx;
    logic [ENTRIES-1:0][ENT_W-1:0] mask_nx;
    logic [ENT_W-1:0]              gm_nx;
    logic [ENTRIES-1:0]            ent_hit;
    logic                          any_hit;
    logic [AW-1:0]                 first_idx;
    grp_mode_e                     mode;
    rsp_t                          rsp_d, rsp_q;

    assign mode = grp_mode_e'(cfg_width);

    tmatch_store #(.ENT_W(ENT_W), .ENTRIES(ENTRIES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_is_mask (wr_is_mask),
        .wr_addr    (wr_addr),
        .wr_word    (wr_word),
        .gm_wr_en   (gm_wr_en),
        .gm_word    (gm_word),
        .data_nx    (data_nx),
        .mask_nx    (mask_nx),
        .gm_nx      (gm_nx)
    );

    tmatch_cmp #(.ENT_W(ENT_W), .ENTRIES(ENTRIES)) u_cmp (
        .key     (srch_key),
        .mode    (mode),
        .data    (data_nx),
        .mask    (mask_nx),
        .gm      (gm_nx),
        .ent_hit (ent_hit)
    );

    tmatch_grp #(.ENTRIES(ENTRIES)) u_grp (
        .ent_hit   (ent_hit),
        .mode      (mode),
        .any_hit   (any_hit),
        .first_idx (first_idx)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = srch_req;
        if (srch_req) begin
            rsp_d.hit = any_hit;
            rsp_d.idx = any_hit ? first_idx : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_idx   = rsp_q.idx;

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req |=> rsp_valid);

    a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_req |=> !rsp_valid);

    a_r9_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_req |=> $stable(rsp_hit) && $stable(rsp_idx));

    a_r10_miss_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> rsp_idx == '0);

    a_r5_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req && cfg_width == 2'd1 |=> !rsp_hit || !rsp_idx[0]);

    a_r6_quad_base: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req && cfg_width == 2'd2 |=> !rsp_hit || rsp_idx[1:0] == 2'b00);

endmodule

// File: tb/tmatch_engine_test.sv
module tmatch_engine_test;

    localparam int W  = 8;
    localparam int N  = 16;
    localparam int AW = 4;
    localparam int KW = 4 * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, wr_is_mask, gm_wr_en, srch_req;
    logic [AW-1:0] wr_addr;
    logic [W-1:0]  wr_word, gm_word;
    logic [1:0]    cfg_width;
    logic [KW-1:0] srch_key;
    logic          rsp_valid, rsp_hit;
    logic [AW-1:0] rsp_idx;

    logic [W-1:0]  m_data [N];
    logic [W-1:0]  m_mask [N];
    logic [W-1:0]  m_gm;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;
    logic [31:0] rs = 32'h1234_5678;

    always #5 clk = ~clk;

    tmatch_engine #(.ENT_W(W), .ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_is_mask(wr_is_mask), .wr_addr(wr_addr), .wr_word(wr_word),
        .gm_wr_en(gm_wr_en), .gm_word(gm_word),
        .cfg_width(cfg_width), .srch_req(srch_req), .srch_key(srch_key),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
    );

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [KW-1:0] key, input logic [1:0] md,
                                  output logic h, output logic [AW-1:0] ix);
        int gs;
        gs = (md == 2'd1) ? 2 : (md == 2'd2) ? 4 : 1;
        h  = 1'b0;
        ix = '0;
        for (int g = N - gs; g >= 0; g -= gs) begin
            logic ok;
            ok = 1'b1;
            for (int k = 0; k < gs; k++) begin
                logic [W-1:0] seg;
                seg = key[k*W +: W];
                if ((~m_gm | ~m_mask[g+k] | ~(seg ^ m_data[g+k])) != {W{1'b1}}) ok = 1'b0;
            end
            if (ok) begin
                h  = 1'b1;
                ix = AW'(g);
            end
        end
    endfunction

    task automatic do_wr(input logic sel, input int a, input logic [W-1:0] w);
        wr_en = 1'b1; wr_is_mask = sel; wr_addr = AW'(a); wr_word = w;
        if (sel) m_mask[a] = w; else m_data[a] = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_gm(input logic [W-1:0] w);
        gm_wr_en = 1'b1; gm_word = w; m_gm = w;
        @(negedge clk);
        gm_wr_en = 1'b0;
    endtask

    task automatic srch_exp(input string tag, input logic [KW-1:0] key, input logic [1:0] md,
                            input logic eh, input logic [AW-1:0] ei);
        srch_req = 1'b1; srch_key = key; cfg_width = md;
        @(negedge clk);
        srch_req = 1'b0;
        chk({tag, " R9 valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " hit"}, 32'(rsp_hit), 32'(eh));
        chk(eh ? {tag, " idx"} : {tag, " R10 miss idx"}, 32'(rsp_idx), 32'(ei));
    endtask

    task automatic srch_model(input string tag, input logic [KW-1:0] key, input logic [1:0] md);
        logic eh;
        logic [AW-1:0] ei;
        model(key, md, eh, ei);
        srch_exp(tag, key, md, eh, ei);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 0; wr_is_mask = 0; wr_addr = '0; wr_word = '0;
        gm_wr_en = 0; gm_word = '0; cfg_width = '0; srch_req = 0; srch_key = '0;
        for (int i = 0; i < N; i++) begin m_data[i] = '0; m_mask[i] = '0; end
        m_gm = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: outputs cleared, table is all wildcard
        chk("R12 valid", 32'(rsp_valid), 0);
        chk("R12 hit", 32'(rsp_hit), 0);
        chk("R12 idx", 32'(rsp_idx), 0);
        srch_exp("R12 wildcard table", 32'h1234_5678, 2'd0, 1'b1, 4'd0);

        for (int i = 0; i < N; i++) do_wr(1'b1, i, 8'hFF);

        // R1 R2 R3: all bit combinations at every position, entry 5
        for (int p = 0; p < W; p++) begin
            for (int c = 0; c < 16; c++) begin
                logic g, m, d, s, eh;
                logic [W-1:0] one;
                g = c[3]; m = c[2]; d = c[1]; s = c[0];
                one = W'(1) << p;
                do_gm((~one) | (g ? one : '0));
                do_wr(1'b1, 5, (~one) | (m ? one : '0));
                do_wr(1'b0, 5, (8'h5A & ~one) | (d ? one : '0));
                eh = !g || !m || (d == s);
                srch_exp(!g ? "R1 global mask off" : (!m ? "R2 entry mask off" : "R3 compare"),
                         {24'h0, (8'h5A & ~one) | (s ? one : '0)}, 2'd0, eh, eh ? 4'd5 : 4'd0);
            end
        end
        do_gm(8'hFF);
        do_wr(1'b1, 5, 8'hFF);
        do_wr(1'b0, 5, 8'h5A);

        // R9: result holds across an idle cycle
        srch_exp("R4 single", 32'h0000_005A, 2'd0, 1'b1, 4'd5);
        @(negedge clk);
        chk("R9 idle valid", 32'(rsp_valid), 0);
        chk("R9 held hit", 32'(rsp_hit), 1);
        chk("R9 held idx", 32'(rsp_idx), 5);

        // R4: upper chunks ignored, single bit difference misses
        srch_exp("R4 upper chunks ignored", 32'hFFFF_FF5A, 2'd0, 1'b1, 4'd5);
        srch_exp("R4 one bit off", 32'h0000_005B, 2'd0, 1'b0, 4'd0);
        srch_exp("R7 code 3 as single", 32'hABCD_EF5A, 2'd3, 1'b1, 4'd5);

        // R8: lowest index wins
        do_wr(1'b0, 3, 8'h77);
        do_wr(1'b0, 9, 8'h77);
        srch_exp("R8 lowest wins", 32'h0000_0077, 2'd0, 1'b1, 4'd3);

        // R5: pair mode
        do_wr(1'b0, 6, 8'h11);
        do_wr(1'b0, 7, 8'h22);
        do_wr(1'b0, 10, 8'h44);
        srch_exp("R5 aligned pair", 32'h0000_2211, 2'd1, 1'b1, 4'd6);
        srch_exp("R5 swapped chunks", 32'h0000_1122, 2'd1, 1'b0, 4'd0);
        srch_exp("R5 unaligned pair", 32'h0000_4477, 2'd1, 1'b0, 4'd0);
        srch_exp("R5 pair at zero", 32'h0000_0000, 2'd1, 1'b1, 4'd0);

        // R6: quad mode
        for (int i = 0; i < 4; i++) do_wr(1'b0, 12 + i, 8'hC0 + 8'(i));
        srch_exp("R6 aligned quad", 32'hC3C2_C1C0, 2'd2, 1'b1, 4'd12);
        srch_exp("R6 unaligned quad", 32'hC000_4477, 2'd2, 1'b0, 4'd0);
        srch_exp("R7 code 2 is quad", 32'h0000_00C0, 2'd2, 1'b0, 4'd0);
        srch_exp("R7 code 0 is single", 32'h0000_00C0, 2'd0, 1'b1, 4'd12);

        // R11: write in the same cycle as the search
        wr_en = 1'b1; wr_is_mask = 1'b0; wr_addr = 4'd2; wr_word = 8'h99; m_data[2] = 8'h99;
        srch_exp("R11 data write first", 32'h0000_0099, 2'd0, 1'b1, 4'd2);
        wr_en = 1'b0;
        srch_exp("R11 before gm write", 32'h0000_0009, 2'd0, 1'b0, 4'd0);
        gm_wr_en = 1'b1; gm_word = 8'h0F; m_gm = 8'h0F;
        srch_exp("R11 gm write first", 32'h0000_0009, 2'd0, 1'b1, 4'd2);
        gm_wr_en = 1'b0;
        do_gm(8'hFF);

        // Random sweep against the arithmetic model, every mode code
        for (int it = 0; it < 3000; it++) begin
            logic [31:0] r;
            logic [1:0] md;
            int gs, base;
            logic [KW-1:0] key;
            r = rnd();
            if (r[1:0] == 2'd0) do_wr(1'b1, int'(r[7:4]), 8'(rnd() | rnd()));
            else if (r[2:0] == 3'd1) do_wr(1'b0, int'(r[11:8]), 8'(rnd()));
            if (r[15:12] == 4'd3) do_gm(8'(rnd() | rnd() | rnd()));
            md = r[17:16];
            gs = (md == 2'd1) ? 2 : (md == 2'd2) ? 4 : 1;
            base = (int'(r[23:20]) / gs) * gs;
            key = KW'(rnd());
            if (r[24]) begin
                for (int k = 0; k < gs; k++) key[k*W +: W] = m_data[base + k];
                if (r[27:25] == 3'd0) key = key ^ (KW'(1) << r[30:28]);
            end
            case (md)
                2'd0:    srch_model("R4 random single", key, md);
                2'd1:    srch_model("R5 random pair", key, md);
                2'd2:    srch_model("R6 random quad", key, md);
                default: srch_model("R7 random code3", key, md);
            endcase
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule